// File: doc/BRIEF.md
# Four-pin bridge PWM steering unit

This block generates a pulse-width modulated waveform with a 10-bit duty value and routes it onto four output pins, A to D, in one of four configurations. Single mode drives only A. Half-bridge mode drives A and B as a complementary pair with a programmable dead gap. Forward and reverse full-bridge modes each modulate one pin, hold its diagonal partner active, and hold the other two pins inactive. A polarity field sets the active level separately for the A/C pair and the B/D pair.

The period counter is the 8-bit period value with two low bits appended, so one period lasts 4*(period_i+1) clocks. The duty value is built from an 8-bit upper part and a 2-bit lower part. Duty and period values are captured only at a period boundary, or at any time while the unit is disabled. Every pin has a flag that shows whether the PWM logic owns it. A pin that is not owned reads 0 and is left to general I/O.

Top module: `pwm_steer`

## Requirements
- R1: While en_i is low, and after reset, every drv_o bit and every pin_o bit is 0, one clock after en_i is sampled low.
- R2: One period lasts 4*(period_i+1) clocks. The counter runs from 0 to {period_i,2'b11} and then wraps to 0.
- R3: The modulated signal is active for exactly duty clocks at the start of each period. duty is {duty_hi_i,duty_lo_i}, with duty_lo_i as the two least significant bits.
- R4: Duty and period are captured only when the counter wraps, or while disabled. A write in the middle of a period leaves the current period unchanged and takes effect in the next one.
- R5: A duty value of at least the period length keeps the modulated signal active for the whole period. A duty value of 0 keeps it inactive.
- R6: cfg_i=2'b00 (single): drv_o=4'b0001, A carries the PWM signal, and B, C and D read 0.
- R7: cfg_i=2'b10 (half-bridge): drv_o=4'b0011, B is the complement of A, and A and B are never active together.
- R8: In half-bridge mode, every rising transition of A or B is delayed by db_i clocks. Falling transitions are not delayed.
- R9: cfg_i=2'b01 (full-bridge forward): drv_o=4'b1111, D is modulated, A is held active, and B and C are held inactive.
- R10: cfg_i=2'b11 (full-bridge reverse): drv_o=4'b1111, B is modulated, C is held active, and A and D are held inactive.
- R11: Polarity is applied after steering and dead-band insertion. pol_i[1]=1 makes A and C active-low. pol_i[0]=1 makes B and D active-low. An inactive driven pin therefore shows the inactive level of its pair.
- R12: pin_o and drv_o change one clock after the counter state and the configuration inputs that produce them. Bit 0 is A, bit 1 is B, bit 2 is C and bit 3 is D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low clears the counter and releases all pins |
| period_i | input | HI_W | Period value (upper counter bits) |
| duty_hi_i | input | HI_W | Upper duty bits |
| duty_lo_i | input | LO_W | Lower duty bits |
| cfg_i | input | 2 | Steering configuration |
| pol_i | input | 2 | Polarity: bit 1 for the A/C pair, bit 0 for the B/D pair |
| db_i | input | DB_W | Dead-band delay in clocks |
| pin_o | output | 4 | Pin levels, bit 0 = A |
| drv_o | output | 4 | Per-pin flag: pin owned by the PWM logic |

## Verification
The bench builds the block with its default widths: an 8-bit period and upper duty, a 2-bit lower duty, and a 6-bit dead-band count. Random segments keep period_i between 0 and 7, so periods last 4 to 32 clocks. Duty values are drawn across and beyond that range. With these values, wrap-around, the full-period and zero-duty extremes, mid-period duty writes and dead gaps longer than the pulse all occur many times within a short run. Directed cases measure pulse width, period length and dead gap directly at the pins.

// File: rtl/pwm_steer_pkg.sv
`timescale 1ns/1ps
package pwm_steer_pkg;
  typedef enum logic [1:0] {
    CFG_SINGLE = 2'b00,
    CFG_FWD    = 2'b01,
    CFG_HALF   = 2'b10,
    CFG_REV    = 2'b11
  } steer_cfg_e;

  localparam int unsigned NPINS = 4;
  localparam int unsigned PIN_A = 0;
  localparam int unsigned PIN_B = 1;
  localparam int unsigned PIN_C = 2;
  localparam int unsigned PIN_D = 3;
endpackage

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase #(
  parameter int unsigned HI_W = 8,
  parameter int unsigned LO_W = 2,
  localparam int unsigned CW = HI_W + LO_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [HI_W-1:0] period_i,
  input  logic [CW-1:0]   duty_i,
  output logic            raw_o
);
  logic [CW-1:0] cnt_q, duty_q, top_q;
  logic          wrap;

  assign wrap = (cnt_q == top_q);

  // duty/period shadowed at wrap so mid-period writes cannot glitch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      duty_q <= '0;
      top_q  <= '0;
    end else if (!en_i || wrap) begin
      cnt_q  <= '0;
      duty_q <= duty_i;
      top_q  <= {period_i, {LO_W{1'b1}}};
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign raw_o = en_i && (cnt_q < duty_q);
endmodule

// File: rtl/pwm_router.sv
`timescale 1ns/1ps
module pwm_router
  import pwm_steer_pkg::*;
(
  input  logic             en_i,
  input  logic [1:0]       cfg_i,
  input  logic             raw_i,
  output logic [NPINS-1:0] lvl_o,
  output logic [NPINS-1:0] drv_o
);
  always_comb begin
    lvl_o = '0;
    drv_o = '0;
    if (en_i) begin
      unique case (steer_cfg_e'(cfg_i))
        CFG_SINGLE: begin
          lvl_o[PIN_A] = raw_i;
          drv_o        = 4'b0001;
        end
        CFG_HALF: begin
          lvl_o[PIN_A] = raw_i;
          lvl_o[PIN_B] = ~raw_i;
          drv_o        = 4'b0011;
        end
        CFG_FWD: begin
          lvl_o[PIN_A] = 1'b1;
          lvl_o[PIN_D] = raw_i;
          drv_o        = 4'b1111;
        end
        CFG_REV: begin
          lvl_o[PIN_C] = 1'b1;
          lvl_o[PIN_B] = raw_i;
          drv_o        = 4'b1111;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pwm_deadband.sv
`timescale 1ns/1ps
module pwm_deadband #(
  parameter int unsigned DB_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_i,
  input  logic [DB_W-1:0] dly_i,
  output logic            out_o
);
  logic [DB_W-1:0] cnt_q;
  logic            out_q;

  // rise is held off until input has been high dly_i clocks; fall passes at once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (!in_i) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (cnt_q >= dly_i) begin
      out_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      out_q <= 1'b0;
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/pwm_steer.sv
`timescale 1ns/1ps
module pwm_steer
  import pwm_steer_pkg::*;
#(
  parameter int unsigned HI_W = 8,
  parameter int unsigned LO_W = 2,
  parameter int unsigned DB_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [HI_W-1:0] period_i,
  input  logic [HI_W-1:0] duty_hi_i,
  input  logic [LO_W-1:0] duty_lo_i,
  input  logic [1:0]      cfg_i,
  input  logic [1:0]      pol_i,
  input  logic [DB_W-1:0] db_i,
  output logic [3:0]      pin_o,
  output logic [3:0]      drv_o
);
  localparam int unsigned CW = HI_W + LO_W;

  logic             raw;
  logic [NPINS-1:0] lvl_c, drv_c, lvl_q;
  logic [NPINS-1:0] drv_q, inv_q;

  pwm_timebase #(.HI_W(HI_W), .LO_W(LO_W)) u_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .period_i (period_i),
    .duty_i   ({duty_hi_i, duty_lo_i}),
    .raw_o    (raw)
  );

  pwm_router u_rt (
    .en_i  (en_i),
    .cfg_i (cfg_i),
    .raw_i (raw),
    .lvl_o (lvl_c),
    .drv_o (drv_c)
  );

  // every pin passes one dead-band flop; only A/B in half-bridge get a nonzero delay
  for (genvar k = 0; k < NPINS; k++) begin : g_ch
    logic [DB_W-1:0] dly;
    assign dly = (steer_cfg_e'(cfg_i) == CFG_HALF && k < 2) ? db_i : '0;
    pwm_deadband #(.DB_W(DB_W)) u_db (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .in_i   (lvl_c[k]),
      .dly_i  (dly),
      .out_o  (lvl_q[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_q <= '0;
      inv_q <= '0;
    end else begin
      drv_q <= drv_c;
      inv_q <= {pol_i[0], pol_i[1], pol_i[0], pol_i[1]};
    end
  end

  // polarity after steering; released pins read 0
  assign pin_o = drv_q & (lvl_q ^ inv_q);
  assign drv_o = drv_q;
endmodule

module pwm_steer_chk #(
  parameter int unsigned DB_W = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic [1:0]      cfg_i,
  input logic [1:0]      pol_i,
  input logic [DB_W-1:0] db_i,
  input logic [3:0]      pin_o,
  input logic [3:0]      drv_o
);
  assert_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (drv_o == 4'b0000 && pin_o == 4'b0000));

  assert_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && cfg_i == 2'b00 |=> (drv_o == 4'b0001 && pin_o[3:1] == 3'b000));

  assert_no_overlap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && cfg_i == 2'b10 && pol_i == 2'b00 |=> !(pin_o[0] && pin_o[1]));

  assert_half_owned_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && cfg_i == 2'b10 |=> drv_o == 4'b0011);

  assert_forward_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && cfg_i == 2'b01 && pol_i == 2'b00 |=> (pin_o[2:0] == 3'b001 && drv_o == 4'b1111));

  assert_reverse_inv_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && cfg_i == 2'b11 && pol_i == 2'b11 |=> (pin_o[0] && !pin_o[2] && pin_o[3]));
endmodule

bind pwm_steer pwm_steer_chk #(.DB_W(DB_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .cfg_i  (cfg_i),
  .pol_i  (pol_i),
  .db_i   (db_i),
  .pin_o  (pin_o),
  .drv_o  (drv_o)
);

// File: tb/sim_pwm_steer.sv
`timescale 1ns/1ps
module sim_pwm_steer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       en = 1'b0;
  logic [7:0] per = '0, dhi = '0;
  logic [1:0] dlo = '0, cfg = '0, pol = '0;
  logic [5:0] db = '0;
  logic [3:0] pin, drv;

  int checks = 0, fails = 0, cyc = 0;
  bit started = 0, done = 0;

  always #2.5 clk = ~clk;

  pwm_steer u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .period_i(per),
    .duty_hi_i(dhi), .duty_lo_i(dlo), .cfg_i(cfg), .pol_i(pol),
    .db_i(db), .pin_o(pin), .drv_o(drv)
  );

  // reference model of the requirements, updated at each rising edge
  logic [9:0] m_cnt = '0, m_duty = '0, m_top = '0;
  logic [3:0] m_lvl = '0, m_drv = '0, m_inv = '0;
  int         m_c[4] = '{0, 0, 0, 0};

  always @(posedge clk) begin
    logic       raw;
    logic [3:0] lv, dv;
    int         dl;
    if (!rst_n) begin
      m_cnt = '0; m_duty = '0; m_top = '0;
      m_lvl = '0; m_drv = '0; m_inv = '0;
      for (int k = 0; k < 4; k++) m_c[k] = 0;
    end else begin
      raw = en && (m_cnt < m_duty);
      lv = '0; dv = '0;
      if (en) begin
        case (cfg)
          2'b00: begin lv = {3'b000, raw}; dv = 4'b0001; end
          2'b10: begin lv = {2'b00, !raw, raw}; dv = 4'b0011; end
          2'b01: begin lv = {raw, 2'b00, 1'b1}; dv = 4'b1111; end
          default: begin lv = {1'b0, 1'b1, raw, 1'b0}; dv = 4'b1111; end
        endcase
      end
      for (int k = 0; k < 4; k++) begin
        dl = (cfg == 2'b10 && k < 2) ? int'(db) : 0;
        if (!lv[k]) begin m_c[k] = 0; m_lvl[k] = 1'b0; end
        else if (m_c[k] >= dl) m_lvl[k] = 1'b1;
        else begin m_c[k]++; m_lvl[k] = 1'b0; end
      end
      m_drv = dv;
      m_inv = {pol[0], pol[1], pol[0], pol[1]};
      if (!en || m_cnt == m_top) begin
        m_cnt = '0; m_duty = {dhi, dlo}; m_top = {per, 2'b11};
      end else m_cnt = m_cnt + 1'b1;
    end
  end

  function automatic string tag_of();
    if (!en) return "R1";
    if (pol != 2'b00) return "R11";
    case (cfg)
      2'b00: return "R6";
      2'b10: return "R8";
      2'b01: return "R9";
      default: return "R10";
    endcase
  endfunction

  // per-cycle comparison against the model (R12 latency included)
  always @(negedge clk) begin
    logic [3:0] ep;
    if (started && rst_n && !done) begin
      ep = m_drv & (m_lvl ^ m_inv);
      checks++;
      if (pin !== ep || drv !== m_drv) begin
        fails++;
        $display("FAIL %s/R12 cycle %0d: pin=%b drv=%b expected pin=%b drv=%b",
                 tag_of(), cyc, pin, drv, ep, m_drv);
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic wait_rise_a();
    logic p;
    int g = 0;
    p = pin[0];
    step();
    while (!(pin[0] && !p) && g < 1000) begin p = pin[0]; step(); g++; end
  endtask

  task automatic measure(output int h, output int l);
    logic p;
    wait_rise_a();
    h = 0; l = 0;
    do begin
      if (pin[0]) h++;
      l++;
      p = pin[0];
      step();
    end while (!(pin[0] && !p) && l < 1000);
  endtask

  task automatic dead_gap(output int g);
    logic p;
    int w = 0;
    p = pin[0];
    step();
    while (!(!pin[0] && p) && w < 1000) begin p = pin[0]; step(); w++; end
    g = 0;
    while (!pin[1] && g < 200) begin g++; step(); end
  endtask

  task automatic finish_up();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_up();
    end
  end

  initial begin
    int h, l, g, n;
    void'($urandom(32'd7031));
    #1 rst_n = 1'b0;
    repeat (3) step();
    started = 1;
    // R1: reset state
    check("R1 reset pins", int'(pin), 0);
    check("R1 reset drv", int'(drv), 0);
    rst_n = 1'b1;
    repeat (2) step();

    // R2/R3: single mode, period 16, duty 9 = {2,1}
    per = 8'd3; dhi = 8'd2; dlo = 2'd1; cfg = 2'b00; pol = 2'b00; en = 1'b1;
    measure(h, l);
    check("R3 high count duty 9", h, 9);
    check("R2 period length 16", l, 16);
    // R3: low bits only, duty 3
    dhi = 8'd0; dlo = 2'd3;
    measure(h, l); measure(h, l);
    check("R3 high count duty 3", h, 3);
    // R2: longer period 4*(6)=24
    per = 8'd5; dhi = 8'd1; dlo = 2'd2;
    measure(h, l); measure(h, l);
    check("R2 period length 24", l, 24);
    check("R3 high count duty 6", h, 6);

    // R4: mid-period write does not touch the running period
    per = 8'd3; dhi = 8'd2; dlo = 2'd1;
    measure(h, l);
    wait_rise_a();
    h = 0;
    for (int i = 0; i < 40; i++) begin
      if (i == 2) begin dhi = 8'd1; dlo = 2'd1; end
      if (pin[0]) h++; else break;
      step();
    end
    check("R4 running period keeps old duty", h, 9);
    measure(h, l);
    check("R4 new duty next period", h, 5);

    // R5: duty beyond period -> always active; duty 0 -> never
    dhi = 8'd5; dlo = 2'd0;
    repeat (40) step();
    n = 0;
    for (int i = 0; i < 40; i++) begin if (pin[0]) n++; step(); end
    check("R5 full-period active", n, 40);
    dhi = 8'd0; dlo = 2'd0;
    repeat (40) step();
    n = 0;
    for (int i = 0; i < 40; i++) begin if (pin[0]) n++; step(); end
    check("R5 zero duty inactive", n, 0);

    // R7/R8: half-bridge dead gap
    cfg = 2'b10; dhi = 8'd2; dlo = 2'd0; db = 6'd5;
    repeat (40) step();
    dead_gap(g);
    check("R8 dead gap 5", g, 5);
    check("R7 drive flags", int'(drv), 3);
    db = 6'd0;
    repeat (40) step();
    dead_gap(g);
    check("R8 dead gap 0", g, 0);

    // R9/R10/R11 static pin levels
    cfg = 2'b01; pol = 2'b00; repeat (4) step();
    check("R9 forward A/B/C", int'(pin[2:0]), 1);
    cfg = 2'b11; repeat (4) step();
    check("R10 reverse A,C,D", int'({pin[3], pin[2], pin[0]}), 2);
    pol = 2'b11; repeat (4) step();
    check("R11 reverse inverted A,C,D", int'({pin[3], pin[2], pin[0]}), 5);
    en = 1'b0; repeat (2) step();
    check("R1 disabled drv", int'(drv), 0);

    // constrained random segments, checked per cycle by the model
    for (int s = 0; s < 60; s++) begin
      per = 8'($urandom_range(0, 7));
      dhi = 8'($urandom_range(0, 9));
      dlo = 2'($urandom_range(0, 3));
      cfg = 2'($urandom_range(0, 3));
      pol = 2'($urandom_range(0, 3));
      db  = 6'($urandom_range(0, 7));
      en  = ($urandom_range(0, 9) != 0);
      n = $urandom_range(20, 150);
      for (int i = 0; i < n; i++) begin
        if ($urandom_range(0, 39) == 0) begin
          dhi = 8'($urandom_range(0, 9));
          dlo = 2'($urandom_range(0, 3));
        end
        step();
      end
    end
    finish_up();
  end
endmodule